// File: doc/BRIEF.md
# Unified Data-Space Decoder with Byte and Word Stack

This block sits between a processor's execution logic and its data storage. It accepts one byte-wide command at a time and sends it to one of five places, chosen by a single 16-bit address. The low addresses hold a file of 32 byte registers. Above them lies a window of I/O ports. Next come three core bytes: the two halves of the stack pointer and a status byte. Every address above those goes to an external SRAM, at an offset measured from the start of the SRAM region. Register and core-byte accesses finish in the cycle they are presented. I/O and SRAM accesses are passed out through valid/ready request ports and finish when the peripheral answers.

The same command port also carries push and pop operations, each of one byte or of one 16-bit word. Their addresses come from the internal stack pointer, and they pass through the same decoder. A stack byte can therefore land in SRAM, in an I/O port or even in the register file. A push writes at the stack pointer and then moves it down. A pop moves it up and then reads. Words are pushed high byte first and popped low byte first, so one word pushed and then popped comes back unchanged.

Top module: `dsd_top`

## Requirements
- R1: Addresses 0..31 read and write the register file entry with the same index. Such a command raises cmd_ready in the cycle it is presented.
- R2: Addresses 32..92 raise io_valid with io_addr equal to the address minus 32. The request carries the write flag and the data byte.
- R3: Address 93 reads and writes the stack pointer bits 7:0, address 94 reads and writes its bits 15:8, and address 95 reads and writes the status byte. Each of these completes in the cycle it is presented.
- R4: Addresses 96 and above raise sram_valid with sram_addr equal to the address minus 96.
- R5: cmd_op encodes 0 as read, 1 as write, 2 as push and 3 as pop. A byte push (cmd_word=0) writes cmd_wdata[7:0] at the stack pointer address and then lowers the pointer by one. A byte pop raises the pointer by one, then reads there and returns the byte in rsp_data[7:0] with rsp_data[15:8] set to zero.
- R6: A word push (cmd_word=1) writes cmd_wdata[15:8] at SP, then cmd_wdata[7:0] at SP-1, and leaves SP lowered by two. A word pop reads SP+1 as the low byte and SP+2 as the high byte, returns {high, low} and leaves SP raised by two.
- R7: After a synchronous active-low reset, the stack pointer is 96 + SRAM_BYTES - 1 and the register file and status byte are zero.
- R8: An I/O or SRAM request stays asserted, with its address and write flag unchanged, until its ready is seen. A command that has an external byte raises cmd_ready only in the cycle of that byte's ready. A single external byte therefore takes latency + 1 cycles.
- R9: A write to address 93 or 94 sets the address used by the next push or pop. The stack pointer changes only when a command byte completes.
- R10: At most one of io_valid and sram_valid is high at any time. A register or core-byte access raises neither of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present; held until cmd_ready |
| cmd_op | input | 2 | 0 read, 1 write, 2 push, 3 pop |
| cmd_word | input | 1 | Push/pop moves a 16-bit word |
| cmd_addr | input | 16 | Data-space address for read/write |
| cmd_wdata | input | 16 | Write byte in [7:0]; word push data |
| cmd_ready | output | 1 | Command completes at this clock edge |
| rsp_data | output | 16 | Read or pop result, valid with cmd_ready |
| io_valid | output | 1 | I/O port request |
| io_write | output | 1 | I/O request is a write |
| io_addr | output | 6 | I/O port offset |
| io_wdata | output | 8 | I/O write byte |
| io_ready | input | 1 | I/O request accepted this cycle |
| io_rdata | input | 8 | I/O read byte, valid with io_ready |
| sram_valid | output | 1 | SRAM request |
| sram_write | output | 1 | SRAM request is a write |
| sram_addr | output | 16 | SRAM byte offset |
| sram_wdata | output | 8 | SRAM write byte |
| sram_ready | input | 1 | SRAM request accepted this cycle |
| sram_rdata | input | 8 | SRAM read byte, valid with sram_ready |

## Verification
The bench builds the block with SRAM_BYTES set to 32 and the other parameters at their defaults. The whole data space then spans only 128 addresses, so every register, every I/O port and every SRAM byte is written and read back. With the small SRAM the reset stack pointer sits at 127. Pushes and pops can then be checked against the top SRAM bytes, and moving the pointer to address 20 sends stack bytes into the register file. The bench models latencies of zero to two cycles on the external ports, so the completion timing can be checked against the request handshake.

// File: rtl/dsd_pkg.sv
// Shared types for the data-space decoder.
// Assumes byte-wide storage everywhere; addresses are unsigned.
package dsd_pkg;

    // Which storage a decoded address lands in.
    typedef enum logic [1:0] {
        TGT_REG  = 2'd0,
        TGT_IO   = 2'd1,
        TGT_CORE = 2'd2,
        TGT_SRAM = 2'd3
    } dsd_target_e;

    // Command kinds on the command port.
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_PUSH  = 2'd2,
        OP_POP   = 2'd3
    } dsd_op_e;

    // Core byte selectors, in address order after the I/O window.
    localparam logic [1:0] CORE_SPL  = 2'd0;
    localparam logic [1:0] CORE_SPH  = 2'd1;
    localparam logic [1:0] CORE_STAT = 2'd2;

endpackage

// File: rtl/dsd_addr_map.sv
// Address decoder: splits a flat data-space address into a target and an
// offset inside that target. Purely combinational.
// Assumes: registers start at 0, I/O follows, then three core bytes, then SRAM.
module dsd_addr_map
    import dsd_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int NUM_REGS = 32,
    parameter int IO_SPAN  = 61,
    parameter int RIDX_W   = $clog2(NUM_REGS),
    parameter int IO_AW    = $clog2(IO_SPAN)
) (
    input  logic [ADDR_W-1:0] addr,
    output dsd_target_e       target,
    output logic [RIDX_W-1:0] reg_idx,
    output logic [IO_AW-1:0]  io_off,
    output logic [1:0]        core_sel,
    output logic [ADDR_W-1:0] sram_off
);
    localparam int IO_BASE   = NUM_REGS;
    localparam int CORE_BASE = IO_BASE + IO_SPAN;
    localparam int SRAM_BASE = CORE_BASE + 3;

    // Region select by ascending boundaries.
    always_comb begin
        if (addr < ADDR_W'(IO_BASE))
            target = TGT_REG;
        else if (addr < ADDR_W'(CORE_BASE))
            target = TGT_IO;
        else if (addr < ADDR_W'(SRAM_BASE))
            target = TGT_CORE;
        else
            target = TGT_SRAM;
    end

    // Offsets relative to each region base.
    always_comb begin
        reg_idx  = RIDX_W'(addr);
        io_off   = IO_AW'(addr - ADDR_W'(IO_BASE));
        core_sel = 2'(addr - ADDR_W'(CORE_BASE));
        sram_off = addr - ADDR_W'(SRAM_BASE);
    end

endmodule

// File: rtl/dsd_regfile.sv
// Byte register file with one write port and one combinational read port.
// Assumes: write takes effect at the clock edge; reset clears every entry.
module dsd_regfile #(
    parameter int NUM_REGS = 32,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data
);
    logic [7:0] q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
        // One storage byte, cleared on reset, loaded when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[g] <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))
                q[g] <= wr_data;
        end
    end

    // Read mux.
    assign rd_data = q[rd_idx];

    AST_REG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> q[$past(wr_idx)] == $past(wr_data)); // R1

endmodule

// File: rtl/dsd_stack_seq.sv
// Stack and byte sequencer: owns the stack pointer, picks the address and
// data byte for the current step of a command, and assembles pop words.
// Assumes: the command is held until its last byte completes; byte_done
// marks a completed byte. Push: write then decrement. Pop: increment then read.
module dsd_stack_seq
    import dsd_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int SP_INIT = 1119
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dsd_op_e           op,
    input  logic              word,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [15:0]       wdata,
    input  logic              byte_done,
    input  logic [7:0]        rbyte,
    input  logic              sp_lo_we,
    input  logic              sp_hi_we,
    input  logic [7:0]        sp_wbyte,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [7:0]        cur_wbyte,
    output logic              last_byte,
    output logic [ADDR_W-1:0] sp,
    output logic [15:0]       rsp_data
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic       step;
    logic       is_stack;
    logic       is_word;
    logic [7:0] lo_q;

    assign is_stack  = (op == OP_PUSH) || (op == OP_POP);
    assign is_word   = word && is_stack;
    assign last_byte = !is_word || step;

    // Address and write byte for the present step.
    always_comb begin
        unique case (op)
            OP_PUSH: cur_addr = sp;
            OP_POP:  cur_addr = sp + ONE;
            default: cur_addr = cmd_addr;
        endcase
        if (is_word && !step)
            cur_wbyte = wdata[15:8];
        else
            cur_wbyte = wdata[7:0];
    end

    // Byte-step counter for word commands.
    always_ff @(posedge clk) begin
        if (!rst_n)
            step <= 1'b0;
        else if (byte_done)
            step <= is_word && !step;
    end

    // Stack pointer: stack motion first, then direct byte writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= ADDR_W'(SP_INIT);
        end else if (byte_done && op == OP_PUSH) begin
            sp <= sp - ONE;
        end else if (byte_done && op == OP_POP) begin
            sp <= sp + ONE;
        end else begin
            if (sp_lo_we) sp[7:0]        <= sp_wbyte;
            if (sp_hi_we) sp[ADDR_W-1:8] <= sp_wbyte[ADDR_W-9:0];
        end
    end

    // Low byte of a word pop, kept for the second step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lo_q <= '0;
        else if (byte_done && op == OP_POP && is_word && !step)
            lo_q <= rbyte;
    end

    // Response assembly.
    assign rsp_data = is_word ? {rbyte, lo_q} : {8'h00, rbyte};

    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && op == OP_PUSH) |=> sp == $past(sp) - ONE); // R5
    AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && op == OP_POP) |=> sp == $past(sp) + ONE); // R5
    AST_SP_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> sp == ADDR_W'(SP_INIT)); // R7
    AST_SP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_done |=> $stable(sp)); // R9

endmodule

// File: rtl/dsd_top.sv
// Data-space decoder top: routes one command at a time to the register file,
// the core bytes (stack pointer halves, status), the I/O port or SRAM.
// Assumes: cmd_* held until cmd_ready; peripherals answer with ready and
// read data in the same cycle; internal targets finish in one cycle.
module dsd_top
    import dsd_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int NUM_REGS   = 32,
    parameter int IO_SPAN    = 61,
    parameter int SRAM_BYTES = 1024,
    parameter int IO_AW      = $clog2(IO_SPAN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic              cmd_word,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [15:0]       cmd_wdata,
    output logic              cmd_ready,
    output logic [15:0]       rsp_data,
    output logic              io_valid,
    output logic              io_write,
    output logic [IO_AW-1:0]  io_addr,
    output logic [7:0]        io_wdata,
    input  logic              io_ready,
    input  logic [7:0]        io_rdata,
    output logic              sram_valid,
    output logic              sram_write,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [7:0]        sram_wdata,
    input  logic              sram_ready,
    input  logic [7:0]        sram_rdata
);
    localparam int RIDX_W    = $clog2(NUM_REGS);
    localparam int SRAM_BASE = NUM_REGS + IO_SPAN + 3;
    localparam int SP_INIT   = SRAM_BASE + SRAM_BYTES - 1;

    dsd_op_e           op_e;
    dsd_target_e       tgt;
    logic [ADDR_W-1:0] cur_addr;
    logic [7:0]        cur_wbyte;
    logic              cur_write;
    logic              last_byte;
    logic [ADDR_W-1:0] sp;
    logic [RIDX_W-1:0] reg_idx;
    logic [IO_AW-1:0]  io_off;
    logic [1:0]        core_sel;
    logic [ADDR_W-1:0] sram_off;
    logic [7:0]        reg_rdata;
    logic [7:0]        rbyte;
    logic [7:0]        status_q;
    logic              byte_done;
    logic              core_we;

    assign op_e      = dsd_op_e'(cmd_op);
    assign cur_write = (op_e == OP_WRITE) || (op_e == OP_PUSH);

    dsd_stack_seq #(
        .ADDR_W  (ADDR_W),
        .SP_INIT (SP_INIT)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op_e),
        .word      (cmd_word),
        .cmd_addr  (cmd_addr),
        .wdata     (cmd_wdata),
        .byte_done (byte_done),
        .rbyte     (rbyte),
        .sp_lo_we  (core_we && core_sel == CORE_SPL),
        .sp_hi_we  (core_we && core_sel == CORE_SPH),
        .sp_wbyte  (cur_wbyte),
        .cur_addr  (cur_addr),
        .cur_wbyte (cur_wbyte),
        .last_byte (last_byte),
        .sp        (sp),
        .rsp_data  (rsp_data)
    );

    dsd_addr_map #(
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS),
        .IO_SPAN  (IO_SPAN),
        .RIDX_W   (RIDX_W),
        .IO_AW    (IO_AW)
    ) u_map (
        .addr     (cur_addr),
        .target   (tgt),
        .reg_idx  (reg_idx),
        .io_off   (io_off),
        .core_sel (core_sel),
        .sram_off (sram_off)
    );

    dsd_regfile #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (RIDX_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (byte_done && cur_write && tgt == TGT_REG),
        .wr_idx  (reg_idx),
        .wr_data (cur_wbyte),
        .rd_idx  (reg_idx),
        .rd_data (reg_rdata)
    );

    // External request outputs follow the current byte step.
    always_comb begin
        io_valid   = cmd_valid && tgt == TGT_IO;
        io_write   = cur_write;
        io_addr    = io_off;
        io_wdata   = cur_wbyte;
        sram_valid = cmd_valid && tgt == TGT_SRAM;
        sram_write = cur_write;
        sram_addr  = sram_off;
        sram_wdata = cur_wbyte;
    end

    // Byte completion: internal at once, external on ready.
    always_comb begin
        unique case (tgt)
            TGT_IO:   byte_done = cmd_valid && io_ready;
            TGT_SRAM: byte_done = cmd_valid && sram_ready;
            default:  byte_done = cmd_valid;
        endcase
    end

    assign cmd_ready = byte_done && last_byte;
    assign core_we   = byte_done && cur_write && tgt == TGT_CORE;

    // Read byte select across targets.
    always_comb begin
        unique case (tgt)
            TGT_REG:  rbyte = reg_rdata;
            TGT_IO:   rbyte = io_rdata;
            TGT_SRAM: rbyte = sram_rdata;
            default: begin
                unique case (core_sel)
                    CORE_SPL: rbyte = sp[7:0];
                    CORE_SPH: rbyte = 8'(sp >> 8);
                    default:  rbyte = status_q;
                endcase
            end
        endcase
    end

    // Status byte storage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= '0;
        else if (core_we && core_sel == CORE_STAT)
            status_q <= cur_wbyte;
    end

    AST_ONE_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({io_valid, sram_valid})); // R10
    AST_IO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        io_valid |-> io_addr < IO_AW'(IO_SPAN)); // R2
    AST_SRAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_valid && !sram_ready) |=> sram_valid && $stable(sram_addr) && $stable(sram_write)); // R8
    AST_IO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && !io_ready) |=> io_valid && $stable(io_addr) && $stable(io_write)); // R8
    AST_EXT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && (io_valid || sram_valid)) |-> (io_ready || sram_ready)); // R8

endmodule

// File: tb/dsd_top_test.sv
`timescale 1ns/1ps
module dsd_top_test;
    localparam int SRAMB = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic        cmd_word = 1'b0;
    logic [15:0] cmd_addr = '0;
    logic [15:0] cmd_wdata = '0;
    logic        cmd_ready;
    logic [15:0] rsp_data;
    logic        io_valid, io_write;
    logic [5:0]  io_addr;
    logic [7:0]  io_wdata;
    logic        io_ready = 1'b0;
    logic [7:0]  io_rdata = '0;
    logic        sram_valid, sram_write;
    logic [15:0] sram_addr;
    logic [7:0]  sram_wdata;
    logic        sram_ready = 1'b0;
    logic [7:0]  sram_rdata = '0;

    logic [7:0] sram_mem [SRAMB];
    logic [7:0] io_mem [61];
    int io_lat = 0, sram_lat = 0, io_cnt = 0, sram_cnt = 0;
    int checks = 0, fails = 0;
    bit done = 0;

    dsd_top #(.SRAM_BYTES(SRAMB)) uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_word(cmd_word),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .cmd_ready(cmd_ready), .rsp_data(rsp_data),
        .io_valid(io_valid), .io_write(io_write), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_ready(io_ready), .io_rdata(io_rdata),
        .sram_valid(sram_valid), .sram_write(sram_write), .sram_addr(sram_addr),
        .sram_wdata(sram_wdata), .sram_ready(sram_ready), .sram_rdata(sram_rdata)
    );

    always #5 clk = ~clk;

    // Peripheral models: ready pulses after a programmable wait.
    always begin
        @(posedge clk);
        #1;
        io_ready   = 1'b0;
        sram_ready = 1'b0;
        #2;
        if (sram_valid) begin
            if (sram_cnt >= sram_lat) begin
                sram_ready = 1'b1;
                sram_rdata = sram_mem[sram_addr[4:0]];
                if (sram_write) sram_mem[sram_addr[4:0]] = sram_wdata;
                sram_cnt = 0;
            end else sram_cnt++;
        end
        if (io_valid) begin
            if (io_cnt >= io_lat) begin
                io_ready = 1'b1;
                io_rdata = io_mem[io_addr];
                if (io_write) io_mem[io_addr] = io_wdata;
                io_cnt = 0;
            end else io_cnt++;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Issue one command at posedge+2; sample at posedge+4.
    task automatic run(input logic [1:0] op, input logic wd, input logic [15:0] a,
                       input logic [15:0] d, output logic [15:0] r,
                       output int cyc, output bit ext);
        cmd_valid = 1'b1; cmd_op = op; cmd_word = wd; cmd_addr = a; cmd_wdata = d;
        cyc = 0; ext = 0;
        forever begin
            #2;
            cyc++;
            if (io_valid || sram_valid) ext = 1;
            if (cmd_ready) begin
                r = rsp_data;
                break;
            end
            @(posedge clk); #2;
        end
        @(posedge clk); #2;
        cmd_valid = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        logic [15:0] r;
        int cyc;
        bit ext;
        for (int i = 0; i < SRAMB; i++) sram_mem[i] = '0;
        for (int i = 0; i < 61; i++) io_mem[i] = '0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(posedge clk); #2;

        // R7 reset state
        run(2'd0, 0, 16'd93, 0, r, cyc, ext); chk("R7", "sp lo", int'(r), 8'h7F);
        run(2'd0, 0, 16'd94, 0, r, cyc, ext); chk("R7", "sp hi", int'(r), 0);
        run(2'd0, 0, 16'd95, 0, r, cyc, ext); chk("R7", "status", int'(r), 0);
        for (int a = 0; a < 32; a++) begin
            run(2'd0, 0, 16'(a), 0, r, cyc, ext); chk("R7", "reg zero", int'(r), 0);
        end

        // R1 register sweep, one cycle, no external request (R10)
        for (int a = 0; a < 32; a++) begin
            run(2'd1, 0, 16'(a), 16'((a * 7 + 3) & 8'hFF), r, cyc, ext);
            chk("R1", "write cycles", cyc, 1);
            chk("R10", "reg no ext", int'(ext), 0);
        end
        for (int a = 0; a < 32; a++) begin
            run(2'd0, 0, 16'(a), 0, r, cyc, ext);
            chk("R1", "reg readback", int'(r), (a * 7 + 3) & 8'hFF);
            chk("R1", "read cycles", cyc, 1);
        end

        // R3 status byte
        run(2'd1, 0, 16'd95, 16'h5A, r, cyc, ext);
        chk("R3", "status cycles", cyc, 1);
        chk("R10", "status no ext", int'(ext), 0);
        run(2'd0, 0, 16'd95, 0, r, cyc, ext); chk("R3", "status read", int'(r), 8'h5A);

        // R2 I/O sweep with varied latency (R8)
        for (int a = 32; a < 93; a++) begin
            io_lat = a % 3;
            run(2'd1, 0, 16'(a), 16'((a * 13 + 1) & 8'hFF), r, cyc, ext);
            chk("R2", "io mem", int'(io_mem[a - 32]), (a * 13 + 1) & 8'hFF);
            chk("R8", "io write cycles", cyc, io_lat + 1);
        end
        for (int a = 32; a < 93; a++) begin
            io_lat = (a + 1) % 3;
            run(2'd0, 0, 16'(a), 0, r, cyc, ext);
            chk("R2", "io read", int'(r), (a * 13 + 1) & 8'hFF);
            chk("R8", "io read cycles", cyc, io_lat + 1);
        end
        io_lat = 0;

        // R4 SRAM sweep
        for (int a = 96; a < 128; a++) begin
            sram_lat = a % 3;
            run(2'd1, 0, 16'(a), 16'((a * 5 + 9) & 8'hFF), r, cyc, ext);
            chk("R4", "sram mem", int'(sram_mem[a - 96]), (a * 5 + 9) & 8'hFF);
            chk("R8", "sram cycles", cyc, sram_lat + 1);
        end
        for (int a = 96; a < 128; a++) begin
            sram_lat = (a + 2) % 3;
            run(2'd0, 0, 16'(a), 0, r, cyc, ext);
            chk("R4", "sram read", int'(r), (a * 5 + 9) & 8'hFF);
        end
        sram_lat = 1;

        // R5 byte push at SP=127
        run(2'd2, 0, 0, 16'h00A5, r, cyc, ext);
        chk("R5", "push byte mem", int'(sram_mem[31]), 8'hA5);
        run(2'd0, 0, 16'd93, 0, r, cyc, ext); chk("R5", "sp after push", int'(r), 8'h7E);

        // R6 word push
        run(2'd2, 1, 0, 16'h1234, r, cyc, ext);
        chk("R6", "push hi", int'(sram_mem[30]), 8'h12);
        chk("R6", "push lo", int'(sram_mem[29]), 8'h34);
        run(2'd0, 0, 16'd93, 0, r, cyc, ext); chk("R6", "sp after word push", int'(r), 8'h7C);
        run(2'd3, 1, 0, 0, r, cyc, ext); chk("R6", "pop word", int'(r), 16'h1234);
        run(2'd0, 0, 16'd93, 0, r, cyc, ext); chk("R6", "sp after word pop", int'(r), 8'h7E);
        run(2'd3, 0, 0, 0, r, cyc, ext); chk("R5", "pop byte", int'(r), 16'h00A5);
        run(2'd0, 0, 16'd93, 0, r, cyc, ext); chk("R5", "sp after pop", int'(r), 8'h7F);

        // R9 SP rewrite steers next push
        run(2'd1, 0, 16'd93, 16'h006E, r, cyc, ext);
        run(2'd2, 0, 0, 16'h005C, r, cyc, ext);
        chk("R9", "push at new sp", int'(sram_mem[14]), 8'h5C);
        run(2'd0, 0, 16'd93, 0, r, cyc, ext); chk("R9", "sp after", int'(r), 8'h6D);
        run(2'd1, 0, 16'd94, 16'h0001, r, cyc, ext);
        run(2'd0, 0, 16'd94, 0, r, cyc, ext); chk("R3", "sp hi write", int'(r), 1);
        run(2'd1, 0, 16'd94, 16'h0000, r, cyc, ext);

        // R9/R1 stack into register space
        run(2'd1, 0, 16'd93, 16'd20, r, cyc, ext);
        run(2'd2, 0, 0, 16'h0077, r, cyc, ext);
        chk("R10", "push to reg no ext", int'(ext), 0);
        chk("R1", "push to reg cycles", cyc, 1);
        run(2'd0, 0, 16'd20, 0, r, cyc, ext); chk("R9", "reg20 via push", int'(r), 8'h77);
        run(2'd0, 0, 16'd93, 0, r, cyc, ext); chk("R5", "sp 19", int'(r), 19);
        run(2'd3, 1, 0, 0, r, cyc, ext);
        chk("R6", "pop word regs", int'(r), 16'h9677);
        chk("R6", "pop word reg cycles", cyc, 2);
        run(2'd0, 0, 16'd93, 0, r, cyc, ext); chk("R6", "sp 21", int'(r), 21);

        // R7 second reset
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #2 rst_n = 1'b1;
        @(posedge clk); #2;
        run(2'd0, 0, 16'd93, 0, r, cyc, ext); chk("R7", "sp lo again", int'(r), 8'h7F);
        run(2'd0, 0, 16'd5, 0, r, cyc, ext);  chk("R7", "reg5 cleared", int'(r), 0);
        run(2'd0, 0, 16'd95, 0, r, cyc, ext); chk("R7", "status cleared", int'(r), 0);

        done = 1;
        summary();
    end
endmodule